// File: doc/BRIEF.md
# Three-Line Handshake Byte Mover

This block moves bytes between a host and a small controller's mailbox. The host and the block share three active-low lines. The host drives in-progress and acknowledge; the block drives request. A direction bit sets which way bytes flow. While in-progress is asserted, every change of in-progress or acknowledge moves one byte.

When the host sends, each such change copies the shift register into an outbound store. When the host receives, each change loads the next byte of a reply packet into the shift register. When in-progress is released, the block reports a finished outbound packet and its length. The controller side fills a reply store and commits it with a length. When idle, the block pulls request low to tell the host that reply bytes are waiting. Every moved byte and every handshake milestone gives a one-cycle shift-register event pulse.

Outside in-progress, a toggle of acknowledge is a keep-alive exchange: request simply follows acknowledge. Decoding packet contents belongs to the logic around this block.

Top module: `hs_xfer_engine`

## Requirements
- R1: After reset, `req_n`=1, `sr_q`=0, `pkt_len`=0, no pulse is high, the outbound store is empty, no reply is pending, the direction is device-to-host (0), and both host lines are taken as inactive (1).
- R2: A line write (`lines_wr`) whose new `tip_n` is 0 and whose new (`tip_n`,`ack_n`) pair differs from the previous pair is a byte trigger. All results of any strobe appear on the outputs one clock after the strobe's edge.
- R3: With direction 1 (host-to-device), a byte trigger appends `sr_q` to the outbound store and pulses `sr_evt` while fewer than OUT_DEPTH bytes are stored. When the store is full, the trigger stores nothing and gives no pulse.
- R4: With direction 0, a byte trigger while reply bytes remain loads the next reply byte into `sr_q` and pulses `sr_evt`. The trigger that delivers the last byte drives `req_n` to 1. With nothing pending, a trigger changes nothing.
- R5: With `tip_n` 1 both before and after a line write, a change of `ack_n` copies the new `ack_n` level onto `req_n` and pulses `sr_evt`.
- R6: A line write that takes `tip_n` from 0 to 1 always pulses `sr_evt`. If the outbound store is non-empty, it also pulses `pkt_done` with `pkt_len` equal to the stored count and empties the store.
- R7: An evaluation with `tip_n` 1 that is not an acknowledge toggle drives `req_n` to 0 while reply bytes remain.
- R8: An accepted `rep_load` restarts reading at byte 0, takes `rep_len` as the length and pulses `sr_evt`. If `tip_n` is 1 and `rep_len` is not 0, it also drives `req_n` to 0.
- R9: A `rep_load` while reply bytes remain, or with `rep_len` above IN_DEPTH, is rejected. It pulses `load_err` and leaves the reply unchanged. `rep_wr` writes made while bytes remain are ignored.
- R10: A direction write (`dir_wr`, `dir_in` 1 = host-to-device), or a line write that changes neither line, moves no byte and gives no `sr_evt`.
- R11: At most one of `lines_wr`, `dir_wr`, `sr_wr`, `rep_wr` and `rep_load` is high in any cycle. `sr_wr` loads `sr_q` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lines_wr | input | 1 | Host updates its two handshake lines |
| tip_n | input | 1 | New in-progress level, active low |
| ack_n | input | 1 | New acknowledge level, active low |
| dir_wr | input | 1 | Host writes the direction bit |
| dir_in | input | 1 | Direction, 1 = host-to-device |
| sr_wr | input | 1 | Host writes the shift register |
| sr_wdata | input | W | Shift register write value |
| sr_q | output | W | Shift register contents |
| req_n | output | 1 | Request line to host, active low |
| sr_evt | output | 1 | Shift-register event pulse |
| rep_wr | input | 1 | Write one reply byte |
| rep_wr_addr | input | clog2(IN_DEPTH) | Reply byte position |
| rep_wr_data | input | W | Reply byte value |
| rep_load | input | 1 | Commit a reply packet |
| rep_len | input | clog2(IN_DEPTH+1) | Reply packet length |
| load_err | output | 1 | Rejected commit pulse |
| pkt_done | output | 1 | Outbound packet complete pulse |
| pkt_len | output | clog2(OUT_DEPTH+1) | Length of last completed packet |
| ob_rd_addr | input | clog2(OUT_DEPTH) | Outbound store read position |
| ob_rd_data | output | W | Outbound store byte at that position |

## Verification
Every registered result is due exactly one clock after the edge that samples its strobe: `sr_q`, `req_n`, `sr_evt`, `pkt_done`, `pkt_len` and `load_err`. The driver raises one strobe at a falling edge and queues the full expected output snapshot at that moment. The monitor pops that snapshot 2 ns after the next rising edge, which is the one cycle where the pulses are high. The outbound store read port is combinational, so its contents are checked only during idle cycles with no strobe and an empty queue.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;
   // direction encoding of the host-controlled direction bit
   localparam logic DIR_TO_DEV   = 1'b1;
   localparam logic DIR_TO_HOST  = 1'b0;
   // idle level of every active-low handshake line
   localparam logic LINE_IDLE    = 1'b1;

   typedef struct packed {
      logic tip_n;
      logic ack_n;
   } hs_lines_t;
endpackage

// File: rtl/hs_outbuf.sv
module hs_outbuf #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          clear,
   output logic [CW-1:0] count,
   output logic          full,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  rd_data
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         initial $fatal(1, "hs_outbuf: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         initial $fatal(1, "hs_outbuf: W must be positive");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];

   assign full    = (count == CW'(DEPTH));
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            count <= '0;
      else if (clear)        count <= '0;
      else if (push && !full) count <= count + CW'(1);
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[count[AW-1:0]] <= din;
   end

   // a push into a full store must leave the count alone
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !clear) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/hs_replybuf.sv
module hs_replybuf #(
   parameter int DEPTH = 128,
   parameter int W     = 8,
   localparam int ICW  = $clog2(DEPTH + 1),
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [W-1:0]   wr_data,
   input  logic           load,
   input  logic [ICW-1:0] load_len,
   input  logic           pop,
   output logic           load_ok,
   output logic           load_err,
   output logic           pending,
   output logic           last,
   output logic [W-1:0]   head
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         initial $fatal(1, "hs_replybuf: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]   mem [DEPTH];
   logic [ICW-1:0] len_q;
   logic [ICW-1:0] idx_q;

   assign pending = (idx_q < len_q);
   assign last    = ((idx_q + ICW'(1)) == len_q);
   assign load_ok = load && !pending && (load_len <= ICW'(DEPTH));
   assign head    = mem[idx_q[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q    <= '0;
         idx_q    <= '0;
         load_err <= 1'b0;
      end else begin
         load_err <= load && !load_ok;
         if (load_ok) begin
            len_q <= load_len;
            idx_q <= '0;
         end else if (pop && pending) begin
            idx_q <= idx_q + ICW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !pending) mem[wr_addr] <= wr_data;
   end

   // a rejected commit while bytes remain keeps the packet and flags it
   assert_reject_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && pending) |=> (load_err && len_q == $past(len_q)));
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
   import hs_xfer_pkg::*;
#(
   parameter int W   = 8,
   parameter int OCW = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           lines_wr,
   input  logic           tip_n,
   input  logic           ack_n,
   input  logic           dir_wr,
   input  logic           dir_in,
   input  logic           sr_wr,
   input  logic [W-1:0]   sr_wdata,
   input  logic           load_ok,
   input  logic           load_nz,
   input  logic           ob_full,
   input  logic [OCW-1:0] ob_count,
   input  logic           rb_pending,
   input  logic           rb_last,
   input  logic [W-1:0]   rb_head,
   output logic           ob_push,
   output logic           ob_clear,
   output logic           rb_pop,
   output logic [W-1:0]   sr_q,
   output logic           req_n,
   output logic           sr_evt,
   output logic           pkt_done,
   output logic [OCW-1:0] pkt_len
);
   hs_lines_t prev_q, nxt;
   logic dir_q, nxt_dir;
   logic eval, changed, byte_trig, sync_tog, end_xfer, idle_eval;

   always_comb begin
      eval      = lines_wr | dir_wr;
      nxt       = lines_wr ? hs_lines_t'{tip_n: tip_n, ack_n: ack_n} : prev_q;
      nxt_dir   = dir_wr ? dir_in : dir_q;
      changed   = (nxt != prev_q);
      byte_trig = eval && !nxt.tip_n && changed;
      ob_push   = byte_trig && (nxt_dir == DIR_TO_DEV) && !ob_full;
      rb_pop    = byte_trig && (nxt_dir == DIR_TO_HOST) && rb_pending;
      sync_tog  = eval && nxt.tip_n && prev_q.tip_n && (nxt.ack_n != prev_q.ack_n);
      end_xfer  = eval && nxt.tip_n && !prev_q.tip_n;
      idle_eval = eval && nxt.tip_n && !sync_tog;
      ob_clear  = end_xfer && (ob_count != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '{tip_n: LINE_IDLE, ack_n: LINE_IDLE};
         dir_q    <= DIR_TO_HOST;
         sr_q     <= '0;
         req_n    <= LINE_IDLE;
         sr_evt   <= 1'b0;
         pkt_done <= 1'b0;
         pkt_len  <= '0;
      end else begin
         sr_evt   <= ob_push | rb_pop | sync_tog | end_xfer | load_ok;
         pkt_done <= ob_clear;
         if (ob_clear) pkt_len <= ob_count;
         if (sr_wr)       sr_q <= sr_wdata;
         else if (rb_pop) sr_q <= rb_head;
         if (rb_pop && rb_last)                     req_n <= 1'b1;
         else if (sync_tog)                         req_n <= nxt.ack_n;
         else if (idle_eval && rb_pending)          req_n <= 1'b0;
         else if (load_ok && prev_q.tip_n && load_nz) req_n <= 1'b0;
         if (eval) begin
            prev_q <= nxt;
            dir_q  <= nxt_dir;
         end
      end
   end

   // a completed packet always comes with a shift-register event
   assert_done_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> sr_evt);
endmodule

// File: rtl/hs_xfer_engine.sv
module hs_xfer_engine #(
   parameter int OUT_DEPTH = 16,
   parameter int IN_DEPTH  = 128,
   parameter int W         = 8,
   localparam int OCW = $clog2(OUT_DEPTH + 1),
   localparam int OAW = $clog2(OUT_DEPTH),
   localparam int ICW = $clog2(IN_DEPTH + 1),
   localparam int IAW = $clog2(IN_DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           lines_wr,
   input  logic           tip_n,
   input  logic           ack_n,
   input  logic           dir_wr,
   input  logic           dir_in,
   input  logic           sr_wr,
   input  logic [W-1:0]   sr_wdata,
   output logic [W-1:0]   sr_q,
   output logic           req_n,
   output logic           sr_evt,
   input  logic           rep_wr,
   input  logic [IAW-1:0] rep_wr_addr,
   input  logic [W-1:0]   rep_wr_data,
   input  logic           rep_load,
   input  logic [ICW-1:0] rep_len,
   output logic           load_err,
   output logic           pkt_done,
   output logic [OCW-1:0] pkt_len,
   input  logic [OAW-1:0] ob_rd_addr,
   output logic [W-1:0]   ob_rd_data
);
   logic           ob_push, ob_clear, ob_full;
   logic [OCW-1:0] ob_count;
   logic           rb_pop, rb_pending, rb_last, load_ok;
   logic [W-1:0]   rb_head;

   hs_outbuf #(.DEPTH(OUT_DEPTH), .W(W)) u_outbuf (
      .clk(clk), .rst_n(rst_n), .push(ob_push), .din(sr_q), .clear(ob_clear),
      .count(ob_count), .full(ob_full), .rd_addr(ob_rd_addr), .rd_data(ob_rd_data)
   );

   hs_replybuf #(.DEPTH(IN_DEPTH), .W(W)) u_replybuf (
      .clk(clk), .rst_n(rst_n), .wr_en(rep_wr), .wr_addr(rep_wr_addr),
      .wr_data(rep_wr_data), .load(rep_load), .load_len(rep_len), .pop(rb_pop),
      .load_ok(load_ok), .load_err(load_err), .pending(rb_pending),
      .last(rb_last), .head(rb_head)
   );

   hs_ctrl #(.W(W), .OCW(OCW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .lines_wr(lines_wr), .tip_n(tip_n), .ack_n(ack_n),
      .dir_wr(dir_wr), .dir_in(dir_in), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
      .load_ok(load_ok), .load_nz(rep_len != '0), .ob_full(ob_full),
      .ob_count(ob_count), .rb_pending(rb_pending), .rb_last(rb_last),
      .rb_head(rb_head), .ob_push(ob_push), .ob_clear(ob_clear), .rb_pop(rb_pop),
      .sr_q(sr_q), .req_n(req_n), .sr_evt(sr_evt), .pkt_done(pkt_done),
      .pkt_len(pkt_len)
   );

   assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({lines_wr, dir_wr, sr_wr, rep_wr, rep_load}) <= 1);

   // the outbound store is already empty when completion is reported
   assert_pkt_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> (ob_count == '0));
endmodule

// File: tb/hs_xfer_engine_tb_top.sv
module hs_xfer_engine_tb_top;
   localparam int OD = 16, ID = 128;
   logic clk = 1'b0, rst_n = 1'b0;
   logic lines_wr = 0, tip_n = 1, ack_n = 1, dir_wr = 0, dir_in = 0, sr_wr = 0;
   logic [7:0] sr_wdata = 0, sr_q, rep_wr_data = 0, ob_rd_data;
   logic req_n, sr_evt, rep_wr = 0, rep_load = 0, load_err, pkt_done;
   logic [6:0] rep_wr_addr = 0;
   logic [7:0] rep_len = 0;
   logic [4:0] pkt_len;
   logic [3:0] ob_rd_addr = 0;

   always #4 clk = ~clk;

   hs_xfer_engine dut_i (.*);

   int total = 0, bad = 0;
   logic [16:0] exp_q[$];
   string tag_q[$];

   // bench model state
   logic [7:0] m_sr = 0, m_ob[OD], m_rep[ID];
   logic m_req = 1, m_t = 1, m_a = 1, m_dir = 0;
   int m_cnt = 0, m_len = 0, m_idx = 0;
   logic [4:0] m_plen = 0;

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic push_exp(bit evt, bit done, bit err, string tag);
      exp_q.push_back({m_sr, m_req, evt, done, m_plen, err});
      tag_q.push_back(tag);
   endtask

   // monitor: results are due one clock after the strobe edge
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         logic [16:0] e, a;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = {sr_q, req_n, sr_evt, pkt_done, pkt_len, load_err};
         check(a == e, t, 32'(a), 32'(e));
      end
   end

   task automatic model_eval(bit lw, bit t, bit a, bit dw, bit d, string tag);
      bit nt, na, nd, evt, done;
      nt = lw ? t : m_t;
      na = lw ? a : m_a;
      nd = dw ? d : m_dir;
      evt = 0; done = 0;
      if (!nt) begin
         if (nt != m_t || na != m_a) begin
            if (nd) begin
               if (m_cnt < OD) begin m_ob[m_cnt] = m_sr; m_cnt++; evt = 1; end
            end else if (m_idx < m_len) begin
               m_sr = m_rep[m_idx]; m_idx++; evt = 1;
               if (m_idx == m_len) m_req = 1;
            end
         end
      end else if (m_t && na != m_a) begin
         m_req = na; evt = 1;
      end else begin
         if (!m_t) begin
            evt = 1;
            if (m_cnt > 0) begin done = 1; m_plen = 5'(m_cnt); m_cnt = 0; end
         end
         if (m_idx < m_len) m_req = 0;
      end
      m_t = nt; m_a = na; m_dir = nd;
      push_exp(evt, done, 0, tag);
   endtask

   task automatic lines(bit t, bit a, string tag);
      @(negedge clk);
      lines_wr = 1; tip_n = t; ack_n = a;
      model_eval(1, t, a, 0, 0, tag);
      @(negedge clk);
      lines_wr = 0;
   endtask

   task automatic set_dir(bit d, string tag);
      @(negedge clk);
      dir_wr = 1; dir_in = d;
      model_eval(0, 0, 0, 1, d, tag);
      @(negedge clk);
      dir_wr = 0;
   endtask

   task automatic write_sr(logic [7:0] v);
      @(negedge clk);
      sr_wr = 1; sr_wdata = v; m_sr = v;
      push_exp(0, 0, 0, "R11 sr write");
      @(negedge clk);
      sr_wr = 0;
   endtask

   task automatic write_rep(int adr, logic [7:0] v);
      @(negedge clk);
      rep_wr = 1; rep_wr_addr = 7'(adr); rep_wr_data = v;
      if (!(m_idx < m_len)) m_rep[adr] = v;
      push_exp(0, 0, 0, "R9 reply write");
      @(negedge clk);
      rep_wr = 0;
   endtask

   task automatic load(int n, string tag);
      bit err, evt;
      @(negedge clk);
      rep_load = 1; rep_len = 8'(n);
      err = 0; evt = 0;
      if (m_idx < m_len || n > ID) err = 1;
      else begin
         m_len = n; m_idx = 0; evt = 1;
         if (m_t && n > 0) m_req = 0;
      end
      push_exp(evt, 0, err, tag);
      @(negedge clk);
      rep_load = 0;
   endtask

   task automatic check_ob(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ob_rd_addr = 4'(i);
         #1;
         check(ob_rd_data == m_ob[i], "R3 outbound content", 32'(ob_rd_data), 32'(m_ob[i]));
      end
   endtask

   initial begin
      #(8 * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check({sr_q, req_n, sr_evt, pkt_done, pkt_len, load_err} == {8'h00, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0},
            "R1 reset outputs", 32'({sr_q, req_n, sr_evt, pkt_done, pkt_len, load_err}), 32'h0100);
      rst_n = 1;
      @(negedge clk);

      // R3 host-to-device, three bytes, R6 completion with length
      set_dir(1, "R10 dir write idle");
      write_sr(8'hA1); lines(0, 1, "R2 R3 first byte");
      write_sr(8'hA2); lines(0, 0, "R3 ack toggle byte");
      write_sr(8'hA3); lines(1, 1, "R3 tip release mid");
      // that release ended a packet of 2; start again
      write_sr(8'hB1); lines(0, 1, "R3 byte");
      lines(0, 1, "R10 no line change");
      set_dir(1, "R10 dir write while active");
      write_sr(8'hB2); lines(0, 0, "R3 byte");
      write_sr(8'hB3); lines(0, 1, "R3 byte");
      lines(1, 1, "R6 end packet len 3");
      check_ob(3);

      // R3 overflow: 18 triggers, only 16 stored
      for (int i = 0; i < 18; i++) begin
         write_sr(8'(8'h10 + i));
         lines(0, (i % 2 == 0) ? 1'b0 : 1'b1, "R3 fill/overflow");
      end
      lines(1, 1, "R6 end packet len 16");
      check_ob(16);
      lines(1, 1, "R6 no end when already idle");

      // R5 keep-alive toggles
      lines(1, 0, "R5 ack low mirrored");
      lines(1, 1, "R5 ack high mirrored");

      // R4 reply path
      set_dir(0, "R10 dir to host");
      write_rep(0, 8'h5A); write_rep(1, 8'h6B); write_rep(2, 8'h7C);
      load(3, "R8 load idle req low");
      load(2, "R9 load while pending rejected");
      write_rep(1, 8'hEE);
      lines(1, 0, "R7 idle eval keeps req low");
      lines(1, 1, "R5 R7 toggle");
      set_dir(0, "R7 dir eval with pending");
      lines(0, 1, "R4 reply byte 0");
      lines(0, 0, "R4 reply byte 1");
      lines(0, 1, "R4 last byte req high");
      lines(0, 0, "R4 nothing pending");
      lines(1, 1, "R6 end with empty outbound");
      load(129, "R9 over-length rejected");

      // R8 load while in progress: no req change
      lines(0, 1, "R4 trigger nothing pending");
      write_rep(0, 8'h11); write_rep(1, 8'h22);
      load(2, "R8 load during transfer");
      lines(0, 0, "R4 byte 0 during");
      lines(0, 1, "R4 last byte");
      lines(1, 1, "R6 release");
      load(0, "R8 zero-length load");
      lines(1, 1, "R7 no pending after empty load");

      repeat (4) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule